// File: doc/BRIEF.md
# One-Time-Programmable Array Read Front End with ECC Status

This block sits between a simple register bus and a one-time-programmable fuse array. It holds two small engines. The command engine sends a short burst of command words to the array. Software uses this to switch the array's error-correction mode on or off. The read engine fetches one array word per request. It keeps the returned data and the array's quality word side by side, and it flags an ECC failure from that quality word.

Software programs the engines through control registers that carry a per-bit write mask. A bit in the low half-word changes only when the matching bit in the upper half-word is also set. Completion of each engine is latched in an interrupt status register whose bits clear when 1 is written to them.

Register map (word index on `bus_addr`):

| Index | Contents |
|---|---|
| 0 | command control: `[0]` start, `[15:8]` device address |
| 1 | command count: `[3:0]` |
| 2 | user select: `[0]` |
| 3 | read address: `[15:0]` |
| 4 | read start (write-only) |
| 5 | interrupt status: `[1]` command done, `[2]` read done |
| 6 | state: `[0]` read busy, `[1]` command busy, `[2]` ECC failure |
| 7 | read data |
| 8 | quality word |
| 12 and up | command words |

The expected ECC command is device address 0x02, then the word 0xFA (write-register opcode 0xC0 ORed with register index 0x3A), then 0x00 to turn ECC on or 0x09 to turn it off.

Top module: `otp_user_rd_ctrl`

## Requirements
- R1: After reset, every readable register (indices 0 to 8 and the command words) reads 0, and `arr_user_sel`, `arr_rd_req` and `arr_cmd_valid` are 0.
- R2: Writes to indices 0 to 3 are masked per bit. Bit i of the low half-word is written only when bit 16+i of the written word is 1; all other bits keep their value.
- R3: When start (index 0 bit 0) is set while the command engine is idle, the engine drives `arr_cmd_valid` for one cycle per command word. It sends words in index order from index 12 upward, with `arr_cmd_dev` equal to index 0 bits [15:8].
- R4: When the last command word has been sent, the start bit clears by itself and interrupt status bit 1 sets. Writing 1 to interrupt status bit 1 or bit 2 clears that bit; writing 0 leaves it unchanged.
- R5: A write to index 4 with bits 0 and 16 both set, while select is 1 and no read is busy, gives a one-cycle `arr_rd_req` pulse with `arr_rd_addr` equal to index 3. The returned data and quality word then read back at indices 7 and 8, and interrupt status bit 2 sets.
- R6: State bit 2 is 1 exactly when bits [7:6] of the stored quality word are both 1 or bit 5 of it is 1.
- R7: A read start written while select is 0 makes no array request and leaves busy at 0.
- R8: State bit 0 is 1 from the accepted start until the data returns. A start written while busy makes no new request and does not disturb the read in flight.
- R9: A count of 0 sends no words and still completes (bit 1 sets). A count above the number of command slots sends only as many words as there are slots.
- R10: `arr_user_sel` follows select bit 0 at index 2; clearing it returns the array to its default owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_en | input | 1 | bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | register word index |
| bus_wdata | input | 32 | write data, mask in upper half |
| bus_rdata | output | 32 | read data, combinational from `bus_addr` |
| arr_cmd_valid | output | 1 | command word present |
| arr_cmd_dev | output | 8 | target device address |
| arr_cmd_word | output | 8 | command word |
| arr_user_sel | output | 1 | user mode owns the array |
| arr_rd_req | output | 1 | one-cycle read request |
| arr_rd_addr | output | 16 | array word address |
| arr_rd_valid | input | 1 | read result valid |
| arr_rd_data | input | DATA_W | array data word |
| arr_rd_qp | input | 8 | quality / ECC status word |

## Verification
The bench drives the ECC command both ways through an array model. It then checks that a forced quality word disappears when ECC is off. A broken sequencer would leave the model in the wrong mode and the quality readback would be wrong. It also probes these cases:
- quality words that sit just inside and just outside the failure rule, such as 0x80, 0x40, 0xC0 and 0x20; an inverted or partial rule gives the wrong flag;
- a start issued mid-read and a start issued with select clear; a design that fails to ignore these shows an extra request in the model's count;
- counts of zero and counts beyond the slot number; a design that gets these wrong hangs without completion or sends junk words;
- mask bits left clear, which must preserve the stored fields.

// File: rtl/otp_user_rd_ctrl.sv
module otp_user_rd_ctrl #(
  parameter int DATA_W    = 16,
  parameter int CMD_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              arr_cmd_valid,
  output logic [7:0]        arr_cmd_dev,
  output logic [7:0]        arr_cmd_word,
  output logic              arr_user_sel,
  output logic              arr_rd_req,
  output logic [15:0]       arr_rd_addr,
  input  logic              arr_rd_valid,
  input  logic [DATA_W-1:0] arr_rd_data,
  input  logic [7:0]        arr_rd_qp
);
  localparam int IDX_W = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;
  localparam logic [3:0] A_CCTRL = 4'd0, A_CCNT = 4'd1, A_USEL = 4'd2, A_UADDR = 4'd3,
                         A_USTART = 4'd4, A_IRQ = 4'd5, A_STATE = 4'd6, A_DATA = 4'd7,
                         A_QP = 4'd8, A_CMD = 4'd12;
  localparam logic [3:0] SLOTS = 4'(CMD_WORDS);

  logic              wr;
  logic              cmd_en, cmd_last;
  logic [7:0]        cmd_dev;
  logic [3:0]        cmd_cnt, cmd_idx, eff_cnt;
  logic [7:0]        cmd_w [CMD_WORDS];
  logic              user_sel, rd_busy, rd_start, ecc_fail;
  logic [15:0]       user_addr;
  logic [DATA_W-1:0] rd_data;
  logic [7:0]        rd_qp;
  logic [2:1]        irq_st, irq_set, irq_clr;

  assign wr       = bus_en & bus_we;
  assign eff_cnt  = (cmd_cnt > SLOTS) ? SLOTS : cmd_cnt;
  assign cmd_last = (cmd_idx + 4'd1) >= eff_cnt;
  assign rd_start = wr && bus_addr == A_USTART && bus_wdata[16] && bus_wdata[0]
                    && user_sel && !rd_busy;
  assign ecc_fail = (rd_qp[7:6] == 2'b11) | rd_qp[5];

  assign arr_cmd_valid = cmd_en && (cmd_idx < eff_cnt);
  assign arr_cmd_dev   = cmd_dev;
  assign arr_cmd_word  = arr_cmd_valid ? cmd_w[cmd_idx[IDX_W-1:0]] : 8'h00;
  assign arr_user_sel  = user_sel;
  assign arr_rd_addr   = user_addr;

  // command sequencer and its registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_en  <= 1'b0;
      cmd_idx <= '0;
      cmd_dev <= '0;
      cmd_cnt <= '0;
      for (int i = 0; i < CMD_WORDS; i++) cmd_w[i] <= '0;
    end else begin
      if (cmd_en) begin
        if (cmd_last) begin
          cmd_en  <= 1'b0;
          cmd_idx <= '0;
        end else begin
          cmd_idx <= cmd_idx + 4'd1;
        end
      end else if (wr && bus_addr == A_CCTRL && bus_wdata[16]) begin
        cmd_en <= bus_wdata[0];
      end
      if (wr && bus_addr == A_CCTRL)
        cmd_dev <= (cmd_dev & ~bus_wdata[31:24]) | (bus_wdata[15:8] & bus_wdata[31:24]);
      if (wr && bus_addr == A_CCNT)
        cmd_cnt <= (cmd_cnt & ~bus_wdata[19:16]) | (bus_wdata[3:0] & bus_wdata[19:16]);
      for (int i = 0; i < CMD_WORDS; i++)
        if (wr && bus_addr == A_CMD + 4'(i)) cmd_w[i] <= bus_wdata[7:0];
    end
  end

  // user read engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_sel   <= 1'b0;
      user_addr  <= '0;
      rd_busy    <= 1'b0;
      arr_rd_req <= 1'b0;
      rd_data    <= '0;
      rd_qp      <= '0;
    end else begin
      if (wr && bus_addr == A_USEL && bus_wdata[16]) user_sel <= bus_wdata[0];
      if (wr && bus_addr == A_UADDR)
        user_addr <= (user_addr & ~bus_wdata[31:16]) | (bus_wdata[15:0] & bus_wdata[31:16]);
      arr_rd_req <= rd_start;
      if (rd_start) begin
        rd_busy <= 1'b1;
      end else if (rd_busy && arr_rd_valid) begin
        rd_busy <= 1'b0;
        rd_data <= arr_rd_data;
        rd_qp   <= arr_rd_qp;
      end
    end
  end

  // interrupt status, set wins over clear
  assign irq_set = {rd_busy & arr_rd_valid & ~rd_start, cmd_en & cmd_last};
  assign irq_clr = (wr && bus_addr == A_IRQ) ? bus_wdata[2:1] : 2'b00;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_st <= '0;
    else        irq_st <= (irq_st & ~irq_clr) | irq_set;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CCTRL: bus_rdata = {16'h0, cmd_dev, 7'h0, cmd_en};
      A_CCNT:  bus_rdata = {28'h0, cmd_cnt};
      A_USEL:  bus_rdata = {31'h0, user_sel};
      A_UADDR: bus_rdata = {16'h0, user_addr};
      A_IRQ:   bus_rdata = {29'h0, irq_st, 1'b0};
      A_STATE: bus_rdata = {29'h0, ecc_fail, cmd_en, rd_busy};
      A_DATA:  bus_rdata = {{(32-DATA_W){1'b0}}, rd_data};
      A_QP:    bus_rdata = {24'h0, rd_qp};
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < CMD_WORDS; i++)
      if (bus_addr == A_CMD + 4'(i)) bus_rdata = {24'h0, cmd_w[i]};
  end

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_req |=> !arr_rd_req);
  // R7
  req_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_req |-> arr_user_sel);
  // R8
  req_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_req |-> (rd_busy && !$past(rd_busy)));
  // R4
  cmd_done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_en) |-> irq_st[1]);
  // R9
  cmd_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cmd_valid |-> (cmd_idx < SLOTS));
endmodule

// File: tb/test_otp_user_rd_ctrl.sv
module test_otp_user_rd_ctrl;
  localparam int DATA_W = 16;
  localparam int CMD_WORDS = 2;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic arr_cmd_valid, arr_user_sel, arr_rd_req;
  logic [7:0] arr_cmd_dev, arr_cmd_word;
  logic [15:0] arr_rd_addr;
  logic arr_rd_valid;
  logic [DATA_W-1:0] arr_rd_data;
  logic [7:0] arr_rd_qp;

  int nchk = 0, nfail = 0;
  int ncmd = 0, nreq = 0;
  logic [7:0] log_dev [16];
  logic [7:0] log_word [16];
  logic ecc_on = 0, pend = 0;
  logic [7:0] inj_qp = 0;
  logic [15:0] m_addr = 0;
  logic [LAT-1:0] vsh = 0;

  always #4 clk = ~clk;

  otp_user_rd_ctrl #(.DATA_W(DATA_W), .CMD_WORDS(CMD_WORDS)) i_otp_user_rd_ctrl (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .arr_cmd_valid, .arr_cmd_dev, .arr_cmd_word, .arr_user_sel,
    .arr_rd_req, .arr_rd_addr, .arr_rd_valid, .arr_rd_data, .arr_rd_qp);

  function automatic logic [15:0] fuse(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction
  function automatic logic exp_fail(input logic [7:0] q);
    return (q[7] & q[6]) | q[5];
  endfunction

  // behavioural fuse array
  always @(posedge clk) begin
    if (arr_cmd_valid) begin
      log_dev[ncmd[3:0]] <= arr_cmd_dev;
      log_word[ncmd[3:0]] <= arr_cmd_word;
      ncmd <= ncmd + 1;
      if (arr_cmd_dev == 8'h02) begin
        if (pend) begin ecc_on <= (arr_cmd_word == 8'h00); pend <= 0; end
        else if (arr_cmd_word == 8'hFA) pend <= 1;
      end
    end
    vsh <= {vsh[LAT-2:0], arr_rd_req & arr_user_sel};
    if (arr_rd_req && arr_user_sel) begin
      m_addr <= arr_rd_addr;
      nreq <= nreq + 1;
    end
  end
  assign arr_rd_valid = vsh[LAT-1];
  assign arr_rd_data  = arr_rd_valid ? fuse(m_addr) : '0;
  assign arr_rd_qp    = arr_rd_valid ? (ecc_on ? inj_qp : 8'h00) : 8'h00;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_en = 1; bus_we = 0;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic wait_irq(input int b, input string tag);
    logic [31:0] v;
    for (int k = 0; k < 200; k++) begin
      rd(4'd5, v);
      if (v[b]) return;
    end
    check(tag, 0, 1);
  endtask

  task automatic send_cmd(input logic [7:0] w1);
    wr(4'd12, 32'hFA);
    wr(4'd13, {24'h0, w1});
    wr(4'd1, 32'h000F_0002);
    wr(4'd0, 32'h0001_0001);
    wait_irq(1, "R4 cmd done");
    wr(4'd5, 32'h2);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [7:0] q, input logic ecc);
    logic [31:0] v;
    inj_qp = q;
    wr(4'd3, {16'hFFFF, a});
    wr(4'd4, 32'h0001_0001);
    wait_irq(2, "R5 read done");
    rd(4'd7, v); check("R5 data", v, {16'h0, fuse(a)});
    rd(4'd8, v); check("R5 quality", v, {24'h0, ecc ? q : 8'h00});
    rd(4'd6, v); check("R6 ecc fail", {31'h0, v[2]}, {31'h0, ecc ? exp_fail(q) : 1'b0});
    wr(4'd5, 32'h4);
    rd(4'd5, v); check("R4 w1c read", v, 0);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] shadow;
    int r0, c0;
    void'($urandom(32'h0715));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); check("R1 reset reg", v, 0);
    end
    check("R1 reset pins", {arr_user_sel, arr_rd_req, arr_cmd_valid}, 0);

    // R2 masked writes
    wr(4'd3, 32'hFFFF_1234); rd(4'd3, v); check("R2 full", v, 32'h1234);
    wr(4'd3, 32'h00FF_0000); rd(4'd3, v); check("R2 partial", v, 32'h1200);
    wr(4'd3, 32'h0000_FFFF); rd(4'd3, v); check("R2 no mask", v, 32'h1200);
    wr(4'd0, 32'hFF00_0201); rd(4'd0, v); check("R2 dev only", v, 32'h0200);
    shadow = 16'h1200;
    for (int k = 0; k < 20; k++) begin
      logic [31:0] w;
      w = $urandom;
      shadow = (shadow & ~w[31:16]) | (w[15:0] & w[31:16]);
      wr(4'd3, w); rd(4'd3, v); check("R2 random", v, {16'h0, shadow});
    end

    // R3 R4: ECC off command
    c0 = ncmd;
    send_cmd(8'h09);
    check("R3 word count", ncmd - c0, 2);
    check("R3 word0", {log_dev[c0[3:0]], log_word[c0[3:0]]}, 16'h02FA);
    check("R3 word1", {log_dev[c0[3:0]+1], log_word[c0[3:0]+1]}, 16'h0209);
    rd(4'd0, v); check("R4 start self-clears", v, 32'h0200);
    rd(4'd5, v); check("R4 cleared", v, 0);
    wr(4'd0, 32'h0001_0001); wait_irq(1, "R4 second");
    wr(4'd5, 32'h0); rd(4'd5, v); check("R4 write 0 keeps", v, 32'h2);
    wr(4'd5, 32'h2); rd(4'd5, v); check("R4 write 1 clears", v, 0);

    // R10
    wr(4'd2, 32'h0001_0001); @(negedge clk); check("R10 select on", arr_user_sel, 1);

    // R6 with ECC disabled: quality suppressed
    do_read(16'h0011, 8'hE0, 0);
    send_cmd(8'h00);
    foreach (inj_qp[i]) ;
    do_read(16'h0022, 8'hC0, 1);
    do_read(16'h0023, 8'h80, 1);
    do_read(16'h0024, 8'h40, 1);
    do_read(16'h0025, 8'h20, 1);
    do_read(16'h0026, 8'h1F, 1);
    for (int k = 0; k < 30; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      do_read(rv[15:0], rv[23:16], 1);
    end

    // R8 start while busy
    r0 = nreq;
    inj_qp = 8'h00;
    wr(4'd3, 32'hFFFF_0100);
    wr(4'd4, 32'h0001_0001);
    rd(4'd6, v); check("R8 busy visible", {31'h0, v[0]}, 1);
    wr(4'd3, 32'hFFFF_0200);
    wr(4'd4, 32'h0001_0001);
    wait_irq(2, "R8 done");
    check("R8 one request", nreq - r0, 1);
    rd(4'd7, v); check("R8 first data", v, {16'h0, fuse(16'h0100)});
    rd(4'd6, v); check("R8 idle", {31'h0, v[0]}, 0);
    wr(4'd5, 32'h4);
    wr(4'd4, 32'h0000_0001);
    repeat (8) @(negedge clk);
    check("R5 start needs mask", nreq - r0, 1);

    // R7 select clear
    wr(4'd2, 32'h0001_0000); @(negedge clk); check("R10 select off", arr_user_sel, 0);
    wr(4'd4, 32'h0001_0001);
    rd(4'd6, v); check("R7 no busy", {31'h0, v[0]}, 0);
    repeat (8) @(negedge clk);
    check("R7 no request", nreq - r0, 1);
    rd(4'd5, v); check("R7 no irq", v, 0);

    // R9 counts
    c0 = ncmd;
    wr(4'd1, 32'h000F_000F); wr(4'd0, 32'h0001_0001);
    wait_irq(1, "R9 large"); wr(4'd5, 32'h2);
    check("R9 clamp", ncmd - c0, CMD_WORDS);
    c0 = ncmd;
    wr(4'd1, 32'h000F_0000); wr(4'd0, 32'h0001_0001);
    wait_irq(1, "R9 zero");
    check("R9 zero words", ncmd - c0, 0);
    rd(4'd0, v); check("R9 zero self-clears", v[0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule